// File: doc/BRIEF.md
# DAC Overdrive Settling Controller

This block sits in front of one channel of a 7-bit high-voltage DAC and shortens the time the output takes to settle when the code changes. A trigger pulse presents a new code together with the previously applied code. If the channel may use overdrive, the block first drives a code that overshoots the target by a fixed voltage step, about 4 V expressed in codes. It holds that code for a time computed from the size and direction of the change, then drives the real target. A high-slew flag stays high for as long as the overshoot code is applied.

The overdrive time is the code difference multiplied by a base tick count. That product is scaled by a programmable eighth-step factor, with a separate factor for rising and for falling changes. A falling change that ends near zero gets a further quarter-step extension. A trigger can also hand the channel over to an external ramp (glide) engine. In that case the overdrive is dropped and a one-cycle start pulse is sent out. New triggers, channel disable and wake from low power each follow fixed pre-emption rules.

Top module: `dac_od_ctrl`

## Requirements
- R1: During and after synchronous reset `dac_code` is 0, and `slew` and `glide_go` are low.
- R2: The overshoot step is 21 codes when `step_sel`=0 and 18 codes when `step_sel`=1. A rising change (new > old) with overdrive first drives min(new+step, 127). The step is taken from `step_sel` as sampled with the trigger.
- R3: A falling change (new < old) with overdrive first drives new−step, or 0 when new < step.
- R4: A trigger whose new code equals the effective old code changes neither `dac_code` nor `slew`.
- R5: For a rising change, `slew` is high for exactly floor(|new−old|·BASE_TICKS·(8+`mul_up`)/8) cycles. After that `dac_code` equals the new code.
- R6: For a falling change, `slew` is high for floor(B·(8+`mul_dn`)/8) + (new < step ? floor(B·`dn_fac`/4) : 0) cycles, where B = |new−old|·BASE_TICKS. After that `dac_code` equals the new code.
- R7: With `turbo_en`=0, an enabled trigger whose code differs from the old one sets `dac_code` to the new code on the next cycle, and `slew` stays low.
- R8: A non-glide trigger while `slew` is high ends the overdrive. On the next cycle `dac_code` is the new code and `slew` is low.
- R9: Dropping `chan_en` while `slew` is high applies the target code on the next cycle with `slew` low. Enabling the channel again does not resume the overdrive.
- R10: With `lowpwr_wake`=1, the old code is taken as 0 for direction, step and time.
- R11: A trigger with `glide_sel`=1 never starts an overdrive. It pulses `glide_go` for one cycle when the code differs or an overdrive is running. A running overdrive is replaced by the target code.
- R12: While `chan_en` is low and no overdrive runs, triggers are ignored and `dac_code` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| trig | input | 1 | One-cycle trigger for a new code |
| new_code | input | 7 | Requested target code |
| old_code | input | 7 | Previously applied code |
| lowpwr_wake | input | 1 | Treat the old code as 0 (first trigger after low power) |
| step_sel | input | 1 | LSB size select: 0 gives a 21-code step, 1 gives an 18-code step |
| turbo_en | input | 1 | Channel may use overdrive |
| glide_sel | input | 1 | Trigger hands over to the ramp engine |
| mul_up | input | 3 | Rising time factor n, scale (8+n)/8 |
| mul_dn | input | 3 | Falling time factor n, scale (8+n)/8 |
| dn_fac | input | 2 | Extra falling time in quarters of the base when the target is below the step |
| dac_code | output | 7 | Code driven into the DAC |
| slew | output | 1 | High while the overshoot code is applied |
| glide_go | output | 1 | One-cycle start pulse to the ramp engine |

## Verification
Every output is a register, so a trigger sampled at one rising edge shows its overshoot code, direct code or glide pulse after that edge. The bench samples half a period later, at the following falling edge. From that falling edge it counts the falling edges on which `slew` is still high and compares the count with the expected duration. It checks that the target code is present on the first falling edge where `slew` is low. Disable and re-trigger pre-emptions are applied at a falling edge and take effect at the next rising edge, so they are also checked one falling edge later.

// File: rtl/dac_od_pkg.sv
package dac_od_pkg;

    localparam int CODE_W   = 7;
    localparam int STEP_189 = 21;
    localparam int STEP_220 = 18;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

    typedef struct packed {
        logic  changed;
        dir_e  dir;
        code_t od_code;
    } od_plan_t;

    function automatic code_t od_step(input logic sel);
        return sel ? code_t'(STEP_220) : code_t'(STEP_189);
    endfunction

    function automatic code_t od_shift(input code_t c, input code_t d, input dir_e dir);
        logic [CODE_W:0] sum;
        sum = {1'b0, c} + {1'b0, d};
        if (dir == DIR_UP)
            return sum[CODE_W] ? '1 : sum[CODE_W-1:0];
        else
            return (c < d) ? '0 : code_t'(c - d);
    endfunction

endpackage

// File: rtl/dac_od_calc.sv
module dac_od_calc
    import dac_od_pkg::*;
#(
    parameter int BASE_TICKS = 4,
    parameter int TIME_W     = 14
) (
    input  code_t             new_code,
    input  code_t             old_code,
    input  logic              lowpwr_wake,
    input  logic              step_sel,
    input  logic [2:0]        mul_up,
    input  logic [2:0]        mul_dn,
    input  logic [1:0]        dn_fac,
    output od_plan_t          plan,
    output logic [TIME_W-1:0] dur
);
    code_t             old_eff;
    code_t             step;
    code_t             diff;
    logic [TIME_W-1:0] base;
    logic [TIME_W-1:0] scaled;
    logic [TIME_W-1:0] extra;
    logic [2:0]        mul;

    always_comb begin
        old_eff      = lowpwr_wake ? '0 : old_code;
        step         = od_step(step_sel);
        plan.changed = (new_code != old_eff);
        plan.dir     = (new_code > old_eff) ? DIR_UP : DIR_DOWN;
        diff         = (plan.dir == DIR_UP) ? code_t'(new_code - old_eff)
                                            : code_t'(old_eff - new_code);
        base         = TIME_W'(diff) * TIME_W'(BASE_TICKS);
        mul          = (plan.dir == DIR_UP) ? mul_up : mul_dn;
        scaled       = (base * (TIME_W'(8) + TIME_W'(mul))) >> 3;
        extra        = (plan.dir == DIR_DOWN && new_code < step)
                       ? ((base * TIME_W'(dn_fac)) >> 2) : '0;
        dur          = scaled + extra;
        plan.od_code = od_shift(new_code, step, plan.dir);
    end
endmodule

// File: rtl/dac_od_timer.sv
module dac_od_timer #(
    parameter int TIME_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    input  logic              abort,
    output logic              busy,
    output logic              expire
);
    logic [TIME_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (abort)
            cnt <= '0;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy   = (cnt != '0);
    assign expire = (cnt == TIME_W'(1));
endmodule

// File: rtl/dac_od_ctrl.sv
module dac_od_ctrl
    import dac_od_pkg::*;
#(
    parameter int BASE_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       chan_en,
    input  logic       trig,
    input  logic [6:0] new_code,
    input  logic [6:0] old_code,
    input  logic       lowpwr_wake,
    input  logic       step_sel,
    input  logic       turbo_en,
    input  logic       glide_sel,
    input  logic [2:0] mul_up,
    input  logic [2:0] mul_dn,
    input  logic [1:0] dn_fac,
    output logic [6:0] dac_code,
    output logic       slew,
    output logic       glide_go
);
    localparam int TIME_W = CODE_W + $clog2(BASE_TICKS + 1) + 3;

    od_plan_t          plan;
    logic [TIME_W-1:0] dur;
    logic              busy;
    logic              expire;
    logic              trig_ok;
    logic              start_od;
    logic              abort;
    code_t             dac_q;
    code_t             target_q;
    logic              glide_q;

    dac_od_calc #(.BASE_TICKS(BASE_TICKS), .TIME_W(TIME_W)) u_calc (
        .new_code    (new_code),
        .old_code    (old_code),
        .lowpwr_wake (lowpwr_wake),
        .step_sel    (step_sel),
        .mul_up      (mul_up),
        .mul_dn      (mul_dn),
        .dn_fac      (dn_fac),
        .plan        (plan),
        .dur         (dur)
    );

    always_comb begin
        trig_ok  = trig & chan_en;
        start_od = trig_ok & ~glide_sel & turbo_en & plan.changed & ~busy;
        abort    = busy & (trig_ok | ~chan_en);
    end

    dac_od_timer #(.TIME_W(TIME_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (start_od),
        .load_val (dur),
        .abort    (abort),
        .busy     (busy),
        .expire   (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_q    <= '0;
            target_q <= '0;
            glide_q  <= 1'b0;
        end else begin
            glide_q <= 1'b0;
            if (!chan_en) begin
                if (busy) dac_q <= target_q;
            end else if (trig) begin
                if (glide_sel) begin
                    if (busy) dac_q <= target_q;
                    glide_q <= busy | plan.changed;
                end else if (busy) begin
                    dac_q    <= new_code;
                    target_q <= new_code;
                end else if (plan.changed) begin
                    target_q <= new_code;
                    dac_q    <= turbo_en ? plan.od_code : new_code;
                end
            end else if (expire) begin
                dac_q <= target_q;
            end
        end
    end

    assign dac_code = dac_q;
    assign slew     = busy;
    assign glide_go = glide_q;
endmodule

// File: rtl/dac_od_ctrl_chk.sv
module dac_od_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       chan_en,
    input logic       trig,
    input logic [6:0] new_code,
    input logic [6:0] old_code,
    input logic       lowpwr_wake,
    input logic       turbo_en,
    input logic       glide_sel,
    input logic [6:0] dac_code,
    input logic       slew,
    input logic       glide_go
);
    logic [6:0] old_eff;
    assign old_eff = lowpwr_wake ? 7'd0 : old_code;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (dac_code == 7'd0 && !slew && !glide_go));

    p_equal_noop_r4: assert property (@(posedge clk) disable iff (rst)
        (!slew && trig && chan_en && new_code == old_eff) |=> ($stable(dac_code) && !slew));

    p_direct_apply_r7: assert property (@(posedge clk) disable iff (rst)
        (!slew && trig && chan_en && !turbo_en && !glide_sel && new_code != old_eff)
        |=> (!slew && dac_code == $past(new_code)));

    p_retrigger_abort_r8: assert property (@(posedge clk) disable iff (rst)
        (slew && trig && chan_en && !glide_sel) |=> (!slew && dac_code == $past(new_code)));

    p_disable_stop_r9: assert property (@(posedge clk) disable iff (rst)
        (slew && !chan_en) |=> !slew);

    p_glide_source_r11: assert property (@(posedge clk) disable iff (rst)
        glide_go |-> $past(trig && chan_en && glide_sel));

    p_disabled_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!chan_en && !slew) |=> ($stable(dac_code) && !slew));
endmodule

bind dac_od_ctrl dac_od_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .chan_en     (chan_en),
    .trig        (trig),
    .new_code    (new_code),
    .old_code    (old_code),
    .lowpwr_wake (lowpwr_wake),
    .turbo_en    (turbo_en),
    .glide_sel   (glide_sel),
    .dac_code    (dac_code),
    .slew        (slew),
    .glide_go    (glide_go)
);

// File: tb/dac_od_ctrl_bench.sv
module dac_od_ctrl_bench;
    localparam int PERIOD = 10;
    localparam int BT     = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chan_en = 1'b1, trig = 1'b0, lowpwr_wake = 1'b0, step_sel = 1'b0;
    logic       turbo_en = 1'b1, glide_sel = 1'b0;
    logic [6:0] new_code = '0, old_code = '0;
    logic [2:0] mul_up = 3'd3, mul_dn = 3'd3;
    logic [1:0] dn_fac = 2'd0;
    logic [6:0] dac_code;
    logic       slew, glide_go;

    int n_chk = 0, n_bad = 0;
    int cur = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    dac_od_ctrl #(.BASE_TICKS(BT)) u_dac_od_ctrl (
        .clk(clk), .rst(rst), .chan_en(chan_en), .trig(trig),
        .new_code(new_code), .old_code(old_code), .lowpwr_wake(lowpwr_wake),
        .step_sel(step_sel), .turbo_en(turbo_en), .glide_sel(glide_sel),
        .mul_up(mul_up), .mul_dn(mul_dn), .dn_fac(dn_fac),
        .dac_code(dac_code), .slew(slew), .glide_go(glide_go)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int stepc(input int s); return s ? 18 : 21; endfunction

    function automatic int exp_od(input int n, input int o, input int s);
        int d = stepc(s);
        if (n > o) return (n + d > 127) ? 127 : n + d;
        return (n < d) ? 0 : n - d;
    endfunction

    function automatic int exp_dur(input int n, input int o, input int s,
                                   input int mu, input int md, input int df);
        int b = ((n > o) ? n - o : o - n) * BT;
        if (n > o) return (b * (8 + mu)) / 8;
        return (b * (8 + md)) / 8 + ((n < stepc(s)) ? (b * df) / 4 : 0);
    endfunction

    task automatic fire(input int n, input int o, input bit lp, input bit s,
                        input bit te, input bit gs);
        @(negedge clk);
        new_code = 7'(n); old_code = 7'(o); lowpwr_wake = lp; step_sel = s;
        turbo_en = te; glide_sel = gs; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0; lowpwr_wake = 1'b0; glide_sel = 1'b0;
    endtask

    // Full overdrive case: overshoot code, duration, final code.
    task automatic od_case(input int n, input int o, input bit lp, input bit s);
        int oe = lp ? 0 : o;
        int cnt = 0;
        fire(n, o, lp, s, 1'b1, 1'b0);
        if (n == oe) begin
            check(dac_code == 7'(cur) && !slew, "R4", int'(dac_code), cur);
            return;
        end
        if (n > oe) check(dac_code == 7'(exp_od(n, oe, s)), lp ? "R10" : "R2",
                          int'(dac_code), exp_od(n, oe, s));
        else        check(dac_code == 7'(exp_od(n, oe, s)), "R3",
                          int'(dac_code), exp_od(n, oe, s));
        while (slew && cnt < 5000) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == exp_dur(n, oe, s, mul_up, mul_dn, dn_fac),
              (n > oe) ? "R5" : "R6", cnt, exp_dur(n, oe, s, mul_up, mul_dn, dn_fac));
        check(dac_code == 7'(n), (n > oe) ? "R5" : "R6", int'(dac_code), n);
        cur = n;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dac_code == 0 && !slew && !glide_go, "R1", int'(dac_code), 0);
        rst = 1'b0;
        @(negedge clk);
        check(dac_code == 0 && !slew, "R1", int'(dac_code), 0);

        // Sweep of code pairs with varied factors
        for (int a = 0; a < 128; a += 11) begin
            for (int b = 0; b < 128; b += 17) begin
                mul_up = 3'(a % 8); mul_dn = 3'(b % 8); dn_fac = 2'((a + b) % 4);
                od_case(b, cur, 1'b0, 1'((a + b) & 1));
                od_case(a, b, 1'b0, 1'(a & 1));
            end
        end
        od_case(127, cur, 1'b0, 1'b0);
        od_case(127, 127, 1'b0, 1'b1);

        // R10: wake from low power treats old as 0
        mul_up = 3'd5;
        od_case(30, 100, 1'b1, 1'b0);

        // R7: direct apply
        fire(90, 30, 1'b0, 1'b0, 1'b0, 1'b0);
        check(dac_code == 7'd90 && !slew, "R7", int'(dac_code), 90);
        cur = 90;

        // R8: re-trigger during overdrive
        fire(10, 90, 1'b0, 1'b0, 1'b1, 1'b0);
        check(slew, "R8", int'(slew), 1);
        repeat (3) @(negedge clk);
        fire(50, 10, 1'b0, 1'b0, 1'b1, 1'b0);
        check(dac_code == 7'd50 && !slew, "R8", int'(dac_code), 50);

        // R9: disable during overdrive, no resume
        fire(110, 50, 1'b0, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chan_en = 1'b0;
        @(negedge clk);
        check(dac_code == 7'd110 && !slew, "R9", int'(dac_code), 110);
        // R12: trigger ignored while disabled
        fire(77, 110, 1'b0, 1'b0, 1'b1, 1'b0);
        check(dac_code == 7'd110 && !slew, "R12", int'(dac_code), 110);
        fire(3, 110, 1'b0, 1'b0, 1'b0, 1'b0);
        check(dac_code == 7'd110, "R12", int'(dac_code), 110);
        chan_en = 1'b1;
        repeat (2) @(negedge clk);
        check(dac_code == 7'd110 && !slew, "R9", int'(dac_code), 110);

        // R11: glide select while overdrive runs
        fire(20, 110, 1'b0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        fire(60, 20, 1'b0, 1'b0, 1'b1, 1'b1);
        check(dac_code == 7'd20 && !slew && glide_go, "R11", int'(dac_code), 20);
        @(negedge clk);
        check(!glide_go, "R11", int'(glide_go), 0);
        // R11: glide select from idle
        fire(60, 20, 1'b0, 1'b0, 1'b1, 1'b1);
        check(dac_code == 7'd20 && !slew && glide_go, "R11", int'(dac_code), 20);
        fire(20, 20, 1'b0, 1'b0, 1'b1, 1'b1);
        check(!glide_go, "R11", int'(glide_go), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule